// File: doc/BRIEF.md
# Convergent Block Floating-Point Normaliser

This unit sits between two stages of a pipelined FFT and renormalises a whole block of complex intermediate results onto a single shared exponent. Each accepted sample carries a signed real and imaginary mantissa. The block's exponent enters as a separate word on the sample flagged as the block start. While the block streams in, the unit counts how many redundant copies of the sign bit each component carries, and it keeps the smallest count seen. That smallest count identifies the component of largest magnitude.

The unit writes the block into one half of a two-bank buffer. When the last sample arrives, it starts replaying that bank, with every mantissa shifted left by the common amount. The new exponent travels beside each replayed sample. The next block is collected into the other bank during the replay, so the unit sustains one sample per clock. The shift is reduced when the lowered exponent would fall below its most negative value, and a block with no non-zero component passes through unscaled.

Top module: `cbfp_norm`

## Requirements
- R1: An asserted `rst_n` (active low) forces `out_valid` and `out_first` low at once, and it discards any block that was only partly collected.
- R2: Each output mantissa equals its input mantissa multiplied by 2^s, with one value s for the whole block. Samples leave in the order they arrived, and the real part is kept separate from the imaginary part.
- R3: The redundant sign count of a DW-bit component is the number of consecutive bits, starting at bit DW-2 and going down, that equal bit DW-1. A zero component therefore counts DW-1. Before R6 and R7 apply, s is the minimum of this count over all 2N components of the block.
- R4: `out_exp` equals `in_exp` minus s, in EW-bit two's complement. `in_exp` is taken from the valid sample that has `in_first` high.
- R5: Scaling never overflows. Every output component keeps the sign of its input, and a block made only of -1 values is shifted by DW-1 to the most negative code.
- R6: If `in_exp` minus the R3 count would fall below -2^(EW-1), then `out_exp` is -2^(EW-1) and s is `in_exp` + 2^(EW-1).
- R7: A block whose 2N components are all zero gets s = 0 and leaves `out_exp` equal to `in_exp`.
- R8: Let the last sample of a block be accepted at clock edge t. Output sample j is then presented after edge t+1+j. `out_valid` stays high for exactly N consecutive cycles, and `out_first` is high only with sample 0.
- R9: Blocks that arrive back to back at one sample per cycle are all delivered, and the first sample of each block follows the last sample of the block before it with no idle cycle.
- R10: `out_exp` holds one value for all N samples of a block.
- R11: A cycle with `in_valid` low has no effect, whatever `in_first`, `in_re`, `in_im` and `in_exp` carry in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input sample strobe |
| in_first | input | 1 | Marks the first sample of a block |
| in_re | input | DW | Real mantissa, two's complement |
| in_im | input | DW | Imaginary mantissa, two's complement |
| in_exp | input | EW | Block exponent, two's complement, sampled with `in_first` |
| out_valid | output | 1 | Output sample strobe |
| out_first | output | 1 | Marks the first output sample of a block |
| out_re | output | DW | Scaled real mantissa |
| out_im | output | DW | Scaled imaginary mantissa |
| out_exp | output | EW | Updated block exponent |

## Verification
The assertions assume that every block reaches the unit as exactly N valid samples, with `in_first` high on the first of them and low on the others. Under that assumption the replay of one bank has always finished, or is on its final sample, when the next block completes. The stimulus keeps to this contract. It drives only whole blocks, either back to back or separated by cycles with `in_valid` low. A deliberately partial block is sent only just before a reset, which discards it.

// File: rtl/cbfp_pkg.sv
package cbfp_pkg;

  // Replay engine state
  typedef enum logic [0:0] {
    RD_IDLE = 1'b0,
    RD_BUSY = 1'b1
  } rd_state_e;

endpackage

// File: rtl/cbfp_rst_sync.sv
module cbfp_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/cbfp_lead_count.sv
// Counts sign-bit copies below the MSB (R3).
module cbfp_lead_count #(
  parameter int DW = 16,
  parameter int LW = $clog2(DW)
) (
  input  logic [DW-1:0] val,
  output logic [LW-1:0] cnt
);

  logic [DW-2:0] eq;
  logic [DW-2:0] run;

  genvar gi;
  for (gi = 0; gi < DW-1; gi++) begin : g_eq
    assign eq[gi] = (val[gi] == val[DW-1]);
  end

  always_comb begin
    logic acc;
    acc = 1'b1;
    for (int k = DW-2; k >= 0; k--) begin
      acc    = acc & eq[k];
      run[k] = acc;
    end
  end

  always_comb begin
    cnt = '0;
    for (int k = 0; k < DW-1; k++) begin
      cnt = cnt + LW'(run[k]);
    end
  end

endmodule

// File: rtl/cbfp_bank_mem.sv
module cbfp_bank_mem #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  parameter int MW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [MW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [MW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/cbfp_scan.sv
// Collects one block, tracks the minimum sign count and derives the shift.
module cbfp_scan
  import cbfp_pkg::*;
#(
  parameter int DW = 16,
  parameter int EW = 8,
  parameter int N  = 16,
  parameter int LW = $clog2(DW),
  parameter int AW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_first,
  input  logic [DW-1:0] in_re,
  input  logic [DW-1:0] in_im,
  input  logic [EW-1:0] in_exp,
  output logic          wr_en,
  output logic          wr_bank,
  output logic [AW-1:0] wr_idx,
  output logic          done,
  output logic [LW-1:0] done_shift,
  output logic [EW-1:0] done_exp
);

  localparam logic [LW-1:0] CNT_MAX = LW'(DW-1);
  localparam logic [AW-1:0] LAST    = AW'(N-1);
  localparam int            XW      = EW + LW;

  logic [AW-1:0] idx_q, idx_d;
  logic [LW-1:0] min_q, min_d;
  logic          nz_q, nz_d;
  logic [EW-1:0] exp_q, exp_d;
  logic          bank_q, bank_d;

  logic [LW-1:0] cnt_re, cnt_im;
  logic [AW-1:0] eff_idx;
  logic [LW-1:0] eff_min, pair_min, blk_min, cand, applied;
  logic          eff_nz, blk_nz, last;
  logic [EW-1:0] eff_exp, headroom;

  cbfp_lead_count #(.DW(DW), .LW(LW)) u_lc_re (.val(in_re), .cnt(cnt_re));
  cbfp_lead_count #(.DW(DW), .LW(LW)) u_lc_im (.val(in_im), .cnt(cnt_im));

  // Block statistics including the current sample
  always_comb begin
    eff_idx  = in_first ? '0 : idx_q;
    eff_min  = in_first ? CNT_MAX : min_q;
    eff_nz   = in_first ? 1'b0 : nz_q;
    eff_exp  = in_first ? in_exp : exp_q;
    pair_min = (cnt_re < cnt_im) ? cnt_re : cnt_im;
    blk_min  = (pair_min < eff_min) ? pair_min : eff_min;
    blk_nz   = eff_nz | (|in_re) | (|in_im);
    last     = (eff_idx == LAST);
  end

  // Shift selection: zero block (R7), exponent floor (R6)
  always_comb begin
    headroom = {~eff_exp[EW-1], eff_exp[EW-2:0]};
    cand     = blk_nz ? blk_min : '0;
    if (XW'(cand) > XW'(headroom)) begin
      applied = LW'(headroom);
    end else begin
      applied = cand;
    end
    done       = in_valid && last;
    done_shift = applied;
    done_exp   = eff_exp - EW'(applied);
  end

  // Next state
  always_comb begin
    idx_d  = idx_q;
    min_d  = min_q;
    nz_d   = nz_q;
    exp_d  = exp_q;
    bank_d = bank_q;
    if (in_valid) begin
      exp_d = eff_exp;
      if (last) begin
        idx_d  = '0;
        min_d  = CNT_MAX;
        nz_d   = 1'b0;
        bank_d = ~bank_q;
      end else begin
        idx_d = eff_idx + AW'(1);
        min_d = blk_min;
        nz_d  = blk_nz;
      end
    end
  end

  // Registers, enabled by in_valid only (R11)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      min_q  <= CNT_MAX;
      nz_q   <= 1'b0;
      exp_q  <= '0;
      bank_q <= 1'b0;
    end else if (in_valid) begin
      idx_q  <= idx_d;
      min_q  <= min_d;
      nz_q   <= nz_d;
      exp_q  <= exp_d;
      bank_q <= bank_d;
    end
  end

  assign wr_en   = in_valid;
  assign wr_bank = bank_q;
  assign wr_idx  = eff_idx;

  // The exponent can only go down when a block is normalised
  p_exp_monotone_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($signed(done_exp) <= $signed(eff_exp)));

  // An all-zero block keeps its exponent
  p_zero_keep_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (done && !blk_nz) |-> (done_exp == eff_exp));

endmodule

// File: rtl/cbfp_replay.sv
// Streams one stored block out, shifted by the common amount.
module cbfp_replay
  import cbfp_pkg::*;
#(
  parameter int DW = 16,
  parameter int EW = 8,
  parameter int N  = 16,
  parameter int LW = $clog2(DW),
  parameter int AW = (N > 1) ? $clog2(N) : 1,
  parameter int MW = $clog2(2*N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            ld_bank,
  input  logic [LW-1:0]   ld_shift,
  input  logic [EW-1:0]   ld_exp,
  input  logic [2*DW-1:0] rd_data,
  output logic [MW-1:0]   rd_addr,
  output logic            out_valid,
  output logic            out_first,
  output logic [DW-1:0]   out_re,
  output logic [DW-1:0]   out_im,
  output logic [EW-1:0]   out_exp
);

  localparam logic [AW-1:0] LAST = AW'(N-1);

  rd_state_e     state_q, state_d;
  logic [AW-1:0] idx_q, idx_d;
  logic          bank_q, bank_d;
  logic [LW-1:0] shift_q, shift_d;
  logic [EW-1:0] exp_q, exp_d;

  logic          busy;
  logic [DW-1:0] raw_re, raw_im, sh_re, sh_im;

  logic          ov_q, of_q;
  logic [DW-1:0] ore_q, oim_q;
  logic [EW-1:0] oexp_q;

  always_comb begin
    busy    = (state_q == RD_BUSY);
    raw_re  = rd_data[2*DW-1:DW];
    raw_im  = rd_data[DW-1:0];
    sh_re   = raw_re << shift_q;
    sh_im   = raw_im << shift_q;
    rd_addr = bank_q ? (MW'(N) + MW'(idx_q)) : MW'(idx_q);
  end

  // Next state
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    bank_d  = bank_q;
    shift_d = shift_q;
    exp_d   = exp_q;
    if (load) begin
      state_d = RD_BUSY;
      idx_d   = '0;
      bank_d  = ld_bank;
      shift_d = ld_shift;
      exp_d   = ld_exp;
    end else if (busy) begin
      if (idx_q == LAST) begin
        state_d = RD_IDLE;
      end else begin
        idx_d = idx_q + AW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RD_IDLE;
      idx_q   <= '0;
      bank_q  <= 1'b0;
      shift_q <= '0;
      exp_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      bank_q  <= bank_d;
      shift_q <= shift_d;
      exp_q   <= exp_d;
    end
  end

  // Output register stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q   <= 1'b0;
      of_q   <= 1'b0;
      ore_q  <= '0;
      oim_q  <= '0;
      oexp_q <= '0;
    end else begin
      ov_q <= busy;
      of_q <= busy && (idx_q == '0);
      if (busy) begin
        ore_q  <= sh_re;
        oim_q  <= sh_im;
        oexp_q <= exp_q;
      end
    end
  end

  assign out_valid = ov_q;
  assign out_first = of_q;
  assign out_re    = ore_q;
  assign out_im    = oim_q;
  assign out_exp   = oexp_q;

  p_no_overflow_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((sh_re[DW-1] == raw_re[DW-1]) && (sh_im[DW-1] == raw_im[DW-1])));

  p_no_overrun_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    load |-> ((state_q == RD_IDLE) || (idx_q == LAST)));

  p_exp_held_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_first) |-> (out_exp == $past(out_exp)));

  p_first_valid_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    out_first |-> out_valid);

endmodule

// File: rtl/cbfp_norm.sv
module cbfp_norm
  import cbfp_pkg::*;
#(
  parameter int DW = 16,
  parameter int EW = 8,
  parameter int N  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_first,
  input  logic [DW-1:0] in_re,
  input  logic [DW-1:0] in_im,
  input  logic [EW-1:0] in_exp,
  output logic          out_valid,
  output logic          out_first,
  output logic [DW-1:0] out_re,
  output logic [DW-1:0] out_im,
  output logic [EW-1:0] out_exp
);

  localparam int LW    = $clog2(DW);
  localparam int AW    = (N > 1) ? $clog2(N) : 1;
  localparam int DEPTH = 2 * N;
  localparam int MW    = $clog2(DEPTH);

  logic          rst_n_s;
  logic          wr_en, wr_bank, done;
  logic [AW-1:0] wr_idx;
  logic [LW-1:0] done_shift;
  logic [EW-1:0] done_exp;
  logic [MW-1:0] waddr, raddr;
  logic [2*DW-1:0] rdata;

  cbfp_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  cbfp_scan #(.DW(DW), .EW(EW), .N(N), .LW(LW), .AW(AW)) u_scan (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .in_valid   (in_valid),
    .in_first   (in_first),
    .in_re      (in_re),
    .in_im      (in_im),
    .in_exp     (in_exp),
    .wr_en      (wr_en),
    .wr_bank    (wr_bank),
    .wr_idx     (wr_idx),
    .done       (done),
    .done_shift (done_shift),
    .done_exp   (done_exp)
  );

  assign waddr = wr_bank ? (MW'(N) + MW'(wr_idx)) : MW'(wr_idx);

  cbfp_bank_mem #(.W(2*DW), .DEPTH(DEPTH), .MW(MW)) u_mem (
    .clk   (clk),
    .we    (wr_en),
    .waddr (waddr),
    .wdata ({in_re, in_im}),
    .raddr (raddr),
    .rdata (rdata)
  );

  cbfp_replay #(.DW(DW), .EW(EW), .N(N), .LW(LW), .AW(AW), .MW(MW)) u_replay (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .load      (done),
    .ld_bank   (wr_bank),
    .ld_shift  (done_shift),
    .ld_exp    (done_exp),
    .rd_data   (rdata),
    .rd_addr   (raddr),
    .out_valid (out_valid),
    .out_first (out_first),
    .out_re    (out_re),
    .out_im    (out_im),
    .out_exp   (out_exp)
  );

endmodule

// File: tb/tb_cbfp_norm.sv
`timescale 1ns/1ps
module tb_cbfp_norm;

  localparam int DW = 16;
  localparam int EW = 6;
  localparam int N  = 4;
  localparam int NROW = 9;

  // Per row: input exponent, expected shift, expected exponent, requirement tag
  localparam int T_EXP  [NROW] = '{0, 5, 10, 3, -7, -30, -32, 31, -20};
  localparam int T_SH   [NROW] = '{6, 5, 0, 0, 0, 2, 0, 15, 12};
  localparam int T_OEXP [NROW] = '{-6, 0, 10, 3, -7, -32, -32, 16, -32};
  localparam int T_REQ  [NROW] = '{3, 3, 2, 3, 7, 6, 6, 5, 6};
  // rows: 0 R3 R4, 1 R3 mixed signs, 2 R2 full scale, 3 R3 most negative,
  // 4 R7 zero block, 5 R6 clamp, 6 R6 at floor, 7 R5 all -1, 8 R6 clamp with min 13
  localparam int T_RE [NROW][N] = '{
    '{256, 0, 0, 0}, '{-3, 2, 512, -512}, '{32767, 1, 2, 3}, '{-32768, 0, 0, 0},
    '{0, 0, 0, 0}, '{1, 0, 0, 0}, '{64, 0, 0, 0}, '{-1, -1, -1, -1}, '{3, -4, 0, 0}};
  localparam int T_IM [NROW][N] = '{
    '{0, 0, 0, 16}, '{7, -8, 0, 1}, '{-1, -1, -1, -1}, '{0, 0, 0, 0},
    '{0, 0, 0, 0}, '{0, 0, 0, 0}, '{0, 0, 0, 0}, '{-1, -1, -1, -1}, '{0, 0, 1, 0}};

  logic          clk, rst_n, in_valid, in_first;
  logic [DW-1:0] in_re, in_im;
  logic [EW-1:0] in_exp;
  logic          out_valid, out_first;
  logic [DW-1:0] out_re, out_im;
  logic [EW-1:0] out_exp;

  int nchk = 0;
  int nfail = 0;
  int edge_cnt = 0;
  int nblk = 0;
  int ob = 0;
  bit done_flag = 0;
  int blk_row [32];
  int blk_edge[32];
  bit blk_b2b [32];

  cbfp_norm #(.DW(DW), .EW(EW), .N(N)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_re(in_re), .in_im(in_im), .in_exp(in_exp),
    .out_valid(out_valid), .out_first(out_first),
    .out_re(out_re), .out_im(out_im), .out_exp(out_exp)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  initial begin
    forever begin
      @(posedge clk);
      edge_cnt++;
    end
  end

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  task automatic check_quiet(input string tag);
    nchk++;
    if (out_valid !== 1'b0 || out_first !== 1'b0) begin
      nfail++;
      $display("FAIL R1 %s: valid/first=%b%b expected 00", tag, out_valid, out_first);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_first = 1'b0;
  endtask

  task automatic send_block(input int r, input bit gaps, input bit b2b);
    for (int s = 0; s < N; s++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_first = (s == 0);
      in_re    = DW'(T_RE[r][s]);
      in_im    = DW'(T_IM[r][s]);
      in_exp   = EW'(T_EXP[r]);
      if (s == N-1) begin
        blk_row[nblk]  = r;
        blk_edge[nblk] = edge_cnt + 1;
        blk_b2b[nblk]  = b2b;
        nblk++;
      end
      if (gaps) begin
        // R11: junk on every input while in_valid is low
        @(negedge clk);
        in_valid = 1'b0;
        in_first = 1'b1;
        in_re    = 16'hA5A5;
        in_im    = 16'h5A5A;
        in_exp   = 6'h15;
      end
    end
  endtask

  // Output monitor: R2 R3 R4 R5 R6 R7 R10 values, R8 R9 timing
  initial begin
    int j;
    int last_first;
    j = 0;
    last_first = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        j = 0;
      end else if (out_valid) begin
        if (ob >= nblk) begin
          nchk++; nfail++;
          $display("FAIL R8 unexpected output: block %0d expected none", ob);
        end else begin
          int r, er, ei;
          r  = blk_row[ob];
          er = T_RE[r][j] * (1 << T_SH[r]);
          ei = T_IM[r][j] * (1 << T_SH[r]);
          nchk++;
          if (int'($signed(out_re)) != er || int'($signed(out_im)) != ei ||
              int'($signed(out_exp)) != T_OEXP[r]) begin
            nfail++;
            $display("FAIL R%0d row %0d sample %0d: got %0d,%0d exp %0d expected %0d,%0d exp %0d",
                     T_REQ[r], r, j, $signed(out_re), $signed(out_im), $signed(out_exp),
                     er, ei, T_OEXP[r]);
          end
          nchk++;
          if (out_first != (j == 0)) begin
            nfail++;
            $display("FAIL R8 first flag sample %0d: got %b expected %b", j, out_first, (j == 0));
          end
          if (j == 0) begin
            nchk++;
            if (edge_cnt != blk_edge[ob] + 1) begin
              nfail++;
              $display("FAIL %s latency block %0d: edge %0d expected %0d",
                       blk_b2b[ob] ? "R9" : "R8", ob, edge_cnt, blk_edge[ob] + 1);
            end
            if (blk_b2b[ob] && ob > 0) begin
              nchk++;
              if (edge_cnt - last_first != N) begin
                nfail++;
                $display("FAIL R9 block spacing: got %0d expected %0d", edge_cnt - last_first, N);
              end
            end
            last_first = edge_cnt;
          end
          j++;
          if (j == N) begin
            j = 0;
            ob++;
          end
        end
      end else if (j != 0) begin
        nchk++; nfail++;
        $display("FAIL R8 gap inside block %0d: got valid=0 at sample %0d expected 1", ob, j);
        j = 0;
        ob++;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      nchk++; nfail++;
      $display("FAIL R8 watchdog: blocks out %0d expected %0d", ob, nblk);
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_first = 1'b0;
    in_re = '0; in_im = '0; in_exp = '0;
    repeat (3) @(negedge clk);
    check_quiet("during reset");        // R1
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_quiet("after release");       // R1

    // Table phase A: back-to-back blocks (R9)
    for (int r = 0; r < 5; r++) send_block(r, 1'b0, r > 0);
    idle();
    repeat (3*N) @(negedge clk);

    // Table phase B: idle cycles with junk between samples (R11)
    for (int r = 5; r < NROW; r++) send_block(r, 1'b1, 1'b0);
    idle();
    repeat (3*N) @(negedge clk);

    // Directed: reset in the middle of a block discards it (R1)
    for (int s = 0; s < 2; s++) begin
      @(negedge clk);
      in_valid = 1'b1; in_first = (s == 0);
      in_re = DW'(T_RE[1][s]); in_im = DW'(T_IM[1][s]); in_exp = EW'(T_EXP[1]);
    end
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0;
    rst_n = 1'b0;
    #1 check_quiet("mid-run reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    send_block(0, 1'b0, 1'b0);
    idle();
    repeat (3*N) @(negedge clk);

    // All blocks delivered (R9)
    nchk++;
    if (ob != nblk) begin
      nfail++;
      $display("FAIL R9 block count: got %0d expected %0d", ob, nblk);
    end
    check_quiet("idle at end");
    summary();
  end

endmodule